// File: doc/BRIEF.md
# Four-Pin General-Purpose I/O Port

This block is a small general-purpose I/O port with four pins, placed on a simple register bus. It has three byte-wide registers, and only the low four bits of each are implemented. A direction register picks, for each pin, whether it drives or listens. An output register holds the levels to drive. A read-only pin-state register reports the state of each pin. Each driving pin normally takes its level from the output register. When the address-output mode is selected, the driving pins pass through an external address nibble instead.

A read of the pin-state register is steered bit by bit. A pin set to drive returns its latched output bit. A pin set to listen returns its live level, taken through a two-flop synchronizer. The port has four control inputs that act on its state:
- Power-on reset clears all state.
- Hardware standby clears all state and floats the pins at once.
- Manual reset leaves the state untouched.
- Software standby leaves the state untouched.

While manual reset or software standby is active, bus writes are refused.

Top module: `gpio_quad_port`

## Requirements
- R1: While `rst_n` is low at a clock edge, the direction and output registers clear to 0. After that edge every `pin_oe` bit is 0 and the pin-state register returns the synchronized pin levels.
- R2: Register select codes on `addr` are:
  - 0: direction
  - 1: output data
  - 2: pin state
  - 3: unused

  A write with `wr_en` high to code 0 or 1 updates bits 3..0 of that register at the rising edge. A read returns those bits in `rdata[3:0]`, and `rdata[7:4]` always reads 0.
- R3: Outside hardware standby, `pin_oe[i]` equals direction bit i. In normal mode (`addr_mode` low), a pin with direction bit 1 drives its output-register bit on `pin_out[i]`.
- R4: With `addr_mode` high, a pin with direction bit 1 drives `ext_addr[i]` rather than the output-register bit.
- R5: Reading code 2 returns, for each bit i, the output-register bit when direction bit i is 1. When direction bit i is 0 it returns `pin_in[i]` as sampled two rising edges earlier.
- R6: Writes to code 2 or code 3 change neither register. Code 3 reads 0.
- R7: While `hw_stby` is high, every `pin_oe` bit is 0 in the same cycle. Both registers clear at the next edge.
- R8: While `mrst_n` is low, both registers keep their contents and writes are ignored.
- R9: While `sw_stby` is high, both registers keep their contents, writes are ignored and the pins keep driving.
- R10: With `rd_en` low, `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| mrst_n | input | 1 | Manual reset, active low, keeps state |
| hw_stby | input | 1 | Hardware standby, clears state and floats pins |
| sw_stby | input | 1 | Software standby, keeps state and blocks writes |
| addr_mode | input | 1 | 1: driving pins carry the external address |
| ext_addr | input | 4 | External address nibble |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| pin_in | input | 4 | Pin levels from the pads |
| pin_out | output | 4 | Pin drive levels, 0 where not driven |
| pin_oe | output | 4 | Pin drive enables |

## Verification
The assertions assume that `rst_n` is held low for at least one edge before any other activity. They also assume that `addr` and the strobes change only between edges, so the combinational read path can be compared against register state in the same cycle. The stimulus drives every input on the falling edge. It holds each standby or manual-reset level across at least one full cycle, and it changes `pin_in` only when the bench can count the two synchronizer edges before it reads code 2.

// File: rtl/gpio_quad_pkg.sv
// Shared definitions for the four-pin I/O port.
// Assumes a two-bit register select on the bus.
package gpio_quad_pkg;

    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_DIR  = 2'd0,
        SEL_OUT  = 2'd1,
        SEL_PIN  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/gpio_quad_sync.sv
// Multi-stage synchronizer for the pin inputs.
// Assumes asynchronous pin levels. The output lags the input by STAGES edges.
module gpio_quad_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage_q [STAGES];

    // Shift the pin levels through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= din;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_quad_regs.sv
// Direction and output-data registers.
// Power-on reset and hardware standby clear them. Manual reset and
// software standby freeze them by refusing writes.
// Assumes the select and strobes are stable around the clock edge.
module gpio_quad_regs
    import gpio_quad_pkg::*;
#(
    parameter int NPINS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mrst_n,
    input  logic             hw_stby,
    input  logic             sw_stby,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] addr,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] ddr_q,
    output logic [NPINS-1:0] odr_q
);

    logic write_ok;

    // A write is accepted only when nothing freezes the port.
    always_comb write_ok = wr_en && mrst_n && !sw_stby;

    // Register update: a clear takes priority, then an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n || hw_stby) begin
            ddr_q <= '0;
            odr_q <= '0;
        end else if (write_ok) begin
            case (reg_sel_e'(addr))
                SEL_DIR: ddr_q <= wdata;
                SEL_OUT: odr_q <= wdata;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_quad_pinmux.sv
// Per-pin drive selection and read-back steering.
// Assumes sync_in is already synchronized to clk.
module gpio_quad_pinmux #(
    parameter int NPINS = 4
) (
    input  logic             hw_stby,
    input  logic             addr_mode,
    input  logic [NPINS-1:0] ext_addr,
    input  logic [NPINS-1:0] ddr_q,
    input  logic [NPINS-1:0] odr_q,
    input  logic [NPINS-1:0] sync_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic [NPINS-1:0] rd_pin
);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic drive;

        // Drive enable: the direction bit, forced off in hardware standby.
        always_comb drive = ddr_q[i] && !hw_stby;

        // Drive level: the address bit or the output bit, 0 when floating.
        always_comb pin_out[i] = drive ? (addr_mode ? ext_addr[i] : odr_q[i]) : 1'b0;

        // Read steering: latched data for outputs, the live pin for inputs.
        always_comb rd_pin[i] = ddr_q[i] ? odr_q[i] : sync_in[i];

        assign pin_oe[i] = drive;
    end

endmodule

// File: rtl/gpio_quad_port.sv
// Top level of the four-pin I/O port on a simple register bus.
// Reads are combinational and writes land on the rising edge.
// Assumes rst_n is low for at least one edge after power-up.
module gpio_quad_port
    import gpio_quad_pkg::*;
#(
    parameter int NPINS = 4,
    parameter int DW    = 8,
    parameter int SYNC  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mrst_n,
    input  logic             hw_stby,
    input  logic             sw_stby,
    input  logic             addr_mode,
    input  logic [NPINS-1:0] ext_addr,
    input  logic [SEL_W-1:0] addr,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe
);

    localparam int PAD = DW - NPINS;

    logic [NPINS-1:0] ddr_q;
    logic [NPINS-1:0] odr_q;
    logic [NPINS-1:0] sync_pin;
    logic [NPINS-1:0] rd_pin;
    logic [NPINS-1:0] rd_sel;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^wdata[DW-1:NPINS];

    gpio_quad_regs #(.NPINS(NPINS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .mrst_n  (mrst_n),
        .hw_stby (hw_stby),
        .sw_stby (sw_stby),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata[NPINS-1:0]),
        .ddr_q   (ddr_q),
        .odr_q   (odr_q)
    );

    gpio_quad_sync #(.W(NPINS), .STAGES(SYNC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (sync_pin)
    );

    gpio_quad_pinmux #(.NPINS(NPINS)) u_mux (
        .hw_stby   (hw_stby),
        .addr_mode (addr_mode),
        .ext_addr  (ext_addr),
        .ddr_q     (ddr_q),
        .odr_q     (odr_q),
        .sync_in   (sync_pin),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .rd_pin    (rd_pin)
    );

    // Read select: pick the register named by addr; the unused code reads 0.
    always_comb begin
        case (reg_sel_e'(addr))
            SEL_DIR: rd_sel = ddr_q;
            SEL_OUT: rd_sel = odr_q;
            SEL_PIN: rd_sel = rd_pin;
            default: rd_sel = '0;
        endcase
    end

    // Read data: reserved bits are 0 and an idle bus returns 0.
    always_comb rdata = rd_en ? {{PAD{1'b0}}, rd_sel} : '0;

endmodule

// File: rtl/gpio_quad_port_chk.sv
// Assertion checker for gpio_quad_port, attached by bind.
// Assumes rst_n is asserted before the first checked edge.
module gpio_quad_port_chk #(
    parameter int NPINS = 4,
    parameter int DW    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mrst_n,
    input logic             hw_stby,
    input logic             sw_stby,
    input logic             addr_mode,
    input logic [NPINS-1:0] ext_addr,
    input logic [1:0]       addr,
    input logic             wr_en,
    input logic             rd_en,
    input logic [DW-1:0]    rdata,
    input logic [NPINS-1:0] pin_out,
    input logic [NPINS-1:0] pin_oe,
    input logic [NPINS-1:0] ddr_q,
    input logic [NPINS-1:0] odr_q
);

    p_oe_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_stby |-> pin_oe == ddr_q);

    p_ext_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        addr_mode |-> ((pin_out ^ ext_addr) & pin_oe) == '0);

    p_pin_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 2'd2) |-> ((rdata[NPINS-1:0] ^ odr_q) & ddr_q) == '0);

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DW-1:NPINS] == '0);

    p_ro_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[1] && !hw_stby) |=> ($stable(ddr_q) && $stable(odr_q)));

    p_float_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |-> pin_oe == '0);

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hw_stby) |-> (ddr_q == '0 && odr_q == '0));

    p_hold_mrst_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mrst_n && !hw_stby) |=> ($stable(ddr_q) && $stable(odr_q)));

    p_hold_sw_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_stby && !hw_stby) |=> ($stable(ddr_q) && $stable(odr_q)));

    p_idle_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rdata == '0);

endmodule

bind gpio_quad_port gpio_quad_port_chk #(.NPINS(NPINS), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mrst_n    (mrst_n),
    .hw_stby   (hw_stby),
    .sw_stby   (sw_stby),
    .addr_mode (addr_mode),
    .ext_addr  (ext_addr),
    .addr      (addr),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rdata     (rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .ddr_q     (ddr_q),
    .odr_q     (odr_q)
);

// File: tb/test_gpio_quad_port.sv
// Scoreboard bench: driver tasks queue expected values and a monitor compares them.
module test_gpio_quad_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mrst_n = 1'b1;
    logic       hw_stby = 1'b0;
    logic       sw_stby = 1'b0;
    logic       addr_mode = 1'b0;
    logic [3:0] ext_addr = '0;
    logic [1:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [3:0] pin_in = '0;
    logic [3:0] pin_out;
    logic [3:0] pin_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        int         kind;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t sb_q[$];
    event  chk_ev;

    always #2 clk = ~clk;

    gpio_quad_port i_gpio_quad_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .mrst_n    (mrst_n),
        .hw_stby   (hw_stby),
        .sw_stby   (sw_stby),
        .addr_mode (addr_mode),
        .ext_addr  (ext_addr),
        .addr      (addr),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .wdata     (wdata),
        .rdata     (rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    // Monitor: pop the expected items and compare them with the outputs.
    initial begin
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    0:       act = rdata;
                    1:       act = {4'b0, pin_oe};
                    default: act = {4'b0, pin_out};
                endcase
                n_checks++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic post(input int kind, input logic [7:0] exp, input string tag);
        #1;
        sb_q.push_back('{kind, exp, tag});
        -> chk_ev;
        #0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        addr  = a;
        rd_en = 1'b1;
        post(0, exp, tag);
    endtask

    task automatic sig(input int kind, input logic [7:0] exp, input string tag);
        @(negedge clk);
        post(kind, exp, tag);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b0;
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        pin_in = 4'b1010;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd(2'd0, 8'h00, "R1 dir after reset");
        rd(2'd1, 8'h00, "R1 out after reset");
        sig(1, 8'h00, "R1 oe after reset");
        rd(2'd2, 8'h0A, "R1 pins read as inputs");

        // R2: write and read back, reserved bits zero
        wr(2'd1, 8'hF5);
        rd(2'd1, 8'h05, "R2 out readback");
        wr(2'd0, 8'hFC);
        rd(2'd0, 8'h0C, "R2 dir readback");

        // R3: drive enables and levels in normal mode
        sig(1, 8'h0C, "R3 oe follows dir");
        sig(2, 8'h04, "R3 out drives data");

        // R5: steering and two-edge latency
        rd(2'd2, 8'h06, "R5 mixed read");
        @(negedge clk);
        pin_in = 4'b0101;
        rd(2'd2, 8'h06, "R5 after one edge");
        rd(2'd2, 8'h05, "R5 after two edges");

        // R4: address-output mode
        @(negedge clk);
        addr_mode = 1'b1;
        ext_addr  = 4'hA;
        post(2, 8'h08, "R4 address on driven pins");
        ext_addr = 4'h5;
        post(2, 8'h04, "R4 address follows input");
        rd(2'd2, 8'h05, "R4 read returns out data");
        @(negedge clk);
        addr_mode = 1'b0;

        // R6: writes to read-only and unused codes
        wr(2'd2, 8'hFF);
        wr(2'd3, 8'hFF);
        rd(2'd0, 8'h0C, "R6 dir untouched");
        rd(2'd1, 8'h05, "R6 out untouched");
        rd(2'd3, 8'h00, "R6 unused code reads 0");

        // R10: idle bus
        @(negedge clk);
        rd_en = 1'b0;
        addr  = 2'd1;
        post(0, 8'h00, "R10 idle read");

        // R9: software standby
        @(negedge clk);
        sw_stby = 1'b1;
        wr(2'd1, 8'h03);
        rd(2'd1, 8'h05, "R9 out held");
        sig(1, 8'h0C, "R9 pins still driven");
        @(negedge clk);
        sw_stby = 1'b0;

        // R8: manual reset
        @(negedge clk);
        mrst_n = 1'b0;
        wr(2'd0, 8'h03);
        rd(2'd0, 8'h0C, "R8 dir held");
        rd(2'd1, 8'h05, "R8 out held");
        @(negedge clk);
        mrst_n = 1'b1;

        // R7: hardware standby
        @(negedge clk);
        hw_stby = 1'b1;
        post(1, 8'h00, "R7 immediate float");
        @(negedge clk);
        hw_stby = 1'b0;
        rd(2'd0, 8'h00, "R7 dir cleared");
        rd(2'd1, 8'h00, "R7 out cleared");

        // R1: power-on reset after activity
        wr(2'd1, 8'h09);
        wr(2'd0, 8'h0F);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd(2'd0, 8'h00, "R1 dir cleared again");
        rd(2'd1, 8'h00, "R1 out cleared again");
        sig(1, 8'h00, "R1 oe cleared again");

        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule